// File: doc/BRIEF.md
# Fractional-Prescaler Baud Clock Generator

This block turns the core clock into the timing enables a serial transceiver needs. Three stages run in series. A prescaler divides by a selectable factor from 1.0 to 16.0 in half steps. A programmable integer divisor follows it. A final fixed divide comes last: by 16 when the link is asynchronous, or by 2 when it is synchronous. The divisor stage emits a single-cycle oversample enable, and the final stage emits a single-cycle bit-rate strobe. Neither output is a derived clock; both are enables in the core clock domain.

A half-integer prescale factor k+0.5 is built from prescaler periods that alternate between k and k+1 core clocks. Over any pair of periods the average is exact. A 5 MHz core clock with a factor of 6.5 and a divisor setting of 4 (divide by 5) gives an asynchronous bit rate of 5e6/520, about 9615 baud. Changes to the factor, the divisor or the mode never cut a period short. Each stage picks up a new setting only when its current count reaches terminal.

Top module: `baud_gen`

## Requirements
- R1: While reset is held, and afterwards while the prescale code is 0, `ovsTick` and `bitStrobe` stay low.
- R2: A prescale code c in 1..31 selects factor (c+1)/2. When c is odd the factor is an integer, and with the divisor setting at 0 the gap between `ovsTick` pulses is exactly (c+1)/2 clocks. Code 1 gives a pulse on every clock.
- R3: When c is even (factor k+0.5) and the divisor setting is 0, consecutive `ovsTick` gaps alternate between k and k+1 clocks.
- R4: The divisor input holds N−1. The `ovsTick` period is N × P clocks, so a setting of 9 with factor 2 gives 20 clocks.
- R5: With `syncMode` low, `bitStrobe` pulses once per 16 `ovsTick` pulses and only in a cycle where `ovsTick` is also high.
- R6: With `syncMode` high, `bitStrobe` pulses once per 2 `ovsTick` pulses.
- R7: Writing code 0 stops both outputs once the prescale period in progress ends. No further pulse appears while the code stays 0.
- R8: A new prescale code takes effect at the next prescaler terminal count. The period in progress keeps its old length, so no short pulse gap occurs.
- R9: With factor 6.5 (code 12), divisor setting 4 and asynchronous mode, the gap between `bitStrobe` pulses is 520 clocks, and any two consecutive `ovsTick` gaps sum to 65 clocks.
- R10: When N × P exceeds 1, `ovsTick` is high for exactly one clock per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| preSel | input | PRE_W (5) | Prescale code; factor (code+1)/2, 0 disables |
| divisor | input | DIV_W (8) | Integer divisor minus one |
| syncMode | input | 1 | 1 selects final divide by SYNC_RATE, 0 by OVS_RATE |
| ovsTick | output | 1 | Single-cycle oversample enable |
| bitStrobe | output | 1 | Single-cycle bit-rate enable |

## Verification
The bench builds the block at its default parameters: a 5-bit prescale code, an 8-bit divisor, and final divides of 16 and 2. These cover every factor from 1.0 to 16.0 and both the asynchronous and synchronous final divides. Small divisor settings keep the measured gaps short. The 6.5 × 5 case still exercises the alternating half-period sequence across a full 16-tick bit frame, and that frame is checked against the 520-clock target. A prescale change made partway through a long period exposes any reload that happens before terminal count.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic run;      // prescaler active (code nonzero)
    logic preTc;    // prescaler terminal count this cycle
    logic ovsTc;    // divisor terminal count this cycle
    logic bitTc;    // final divide terminal count this cycle
    logic longPer;  // next half-factor period takes the extra clock
  } bg_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic preZero;
    logic divZero;
    logic finZero;
  } bg_status_t;

endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] preSel,
  input  bg_status_t       status,
  output bg_strobe_t       strobes
);

  logic [PRE_W-1:0] activeCode;
  logic             halfPhase;
  logic             run;
  logic             preTc;
  logic             ovsTc;
  logic             newIsHalf;

  assign run       = (activeCode != '0);
  assign preTc     = run && status.preZero;
  assign ovsTc     = preTc && status.divZero;
  // an even code means (code+1) is odd, i.e. a k+0.5 factor
  assign newIsHalf = ~preSel[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCode <= '0;
      halfPhase  <= 1'b0;
    end else begin
      if (!run || preTc) begin
        activeCode <= preSel;
      end
      if (!run) begin
        halfPhase <= 1'b0;
      end else if (preTc && newIsHalf) begin
        halfPhase <= ~halfPhase;
      end
    end
  end

  always_comb begin
    strobes.run     = run;
    strobes.preTc   = preTc;
    strobes.ovsTc   = ovsTc;
    strobes.bitTc   = ovsTc && status.finZero;
    strobes.longPer = halfPhase && newIsHalf;
  end

endmodule

// File: rtl/baud_gen_dp.sv
module baud_gen_dp
  import baud_gen_pkg::*;
#(
  parameter int PRE_W     = 5,
  parameter int DIV_W     = 8,
  parameter int OVS_RATE  = 16,
  parameter int SYNC_RATE = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PRE_W-1:0]              preSel,
  input  logic [DIV_W-1:0]              divisor,
  input  logic                          syncMode,
  input  bg_strobe_t                    strobes,
  output bg_status_t                    status,
  output logic [PRE_W-2:0]              preCnt,
  output logic [DIV_W-1:0]              divCnt,
  output logic [$clog2(OVS_RATE)-1:0]   finCnt
);

  localparam int CNT_W = PRE_W - 1;
  localparam int FIN_W = $clog2(OVS_RATE);
  localparam logic [FIN_W-1:0] ASYNC_LAST = FIN_W'(OVS_RATE - 1);
  localparam logic [FIN_W-1:0] SYNC_LAST  = FIN_W'(SYNC_RATE - 1);

  logic [PRE_W:0]   baseHalf;
  logic [PRE_W:0]   preReloadWide;
  logic [CNT_W-1:0] preReload;
  logic [FIN_W-1:0] finReload;

  // factor in half units is code+1; whole part is (code+1)>>1
  always_comb begin
    baseHalf      = ({1'b0, preSel} + 1'b1) >> 1;
    preReloadWide = baseHalf - 1'b1 + {{PRE_W{1'b0}}, strobes.longPer};
    preReload     = preReloadWide[CNT_W-1:0];
    finReload     = syncMode ? SYNC_LAST : ASYNC_LAST;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.run) begin
      preCnt <= '0;
      divCnt <= '0;
      finCnt <= '0;
    end else begin
      if (strobes.preTc) begin
        preCnt <= preReload;
      end else begin
        preCnt <= preCnt - 1'b1;
      end
      if (strobes.ovsTc) begin
        divCnt <= divisor;
      end else if (strobes.preTc) begin
        divCnt <= divCnt - 1'b1;
      end
      if (strobes.bitTc) begin
        finCnt <= finReload;
      end else if (strobes.ovsTc) begin
        finCnt <= finCnt - 1'b1;
      end
    end
  end

  assign status.preZero = (preCnt == '0);
  assign status.divZero = (divCnt == '0);
  assign status.finZero = (finCnt == '0);

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int PRE_W     = 5,
  parameter int DIV_W     = 8,
  parameter int OVS_RATE  = 16,
  parameter int SYNC_RATE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] preSel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             syncMode,
  output logic             ovsTick,
  output logic             bitStrobe
);

  localparam int FIN_W = $clog2(OVS_RATE);

  bg_strobe_t       strobes;
  bg_status_t       status;
  logic [PRE_W-2:0] preCnt;
  logic [DIV_W-1:0] divCnt;
  logic [FIN_W-1:0] finCnt;

  baud_gen_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .preSel  (preSel),
    .status  (status),
    .strobes (strobes)
  );

  baud_gen_dp #(
    .PRE_W    (PRE_W),
    .DIV_W    (DIV_W),
    .OVS_RATE (OVS_RATE),
    .SYNC_RATE(SYNC_RATE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .preSel  (preSel),
    .divisor (divisor),
    .syncMode(syncMode),
    .strobes (strobes),
    .status  (status),
    .preCnt  (preCnt),
    .divCnt  (divCnt),
    .finCnt  (finCnt)
  );

  assign ovsTick   = strobes.ovsTc;
  assign bitStrobe = strobes.bitTc;

endmodule

// File: rtl/baud_gen_checker.sv
module baud_gen_checker #(
  parameter int PRE_W = 5,
  parameter int DIV_W = 8,
  parameter int FIN_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             preTc,
  input logic             longPer,
  input logic [PRE_W-2:0] preCnt,
  input logic [DIV_W-1:0] divCnt,
  input logic [FIN_W-1:0] finCnt,
  input logic             ovsTick,
  input logic             bitStrobe
);

  // R5: bit strobe only ever coincides with an oversample tick
  p_bit_on_ovs_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> ovsTick);

  // R7: an idle prescaler leaves all counters cleared
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (preCnt == '0 && divCnt == '0 && finCnt == '0));

  // R8: prescaler counts down one per clock, never reloads mid-period
  p_no_runt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (run && !preTc) |=> (preCnt == $past(preCnt) - 1'b1));

  // R4: divisor counter moves only on a prescaler tick
  p_div_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (run && !preTc) |=> $stable(divCnt));

  // R6: final counter moves only on an oversample tick
  p_fin_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (run && !ovsTick) |=> $stable(finCnt));

  // R3: half-period phase changes only at a prescaler tick
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (run && !preTc) |=> $stable(longPer) || !run);

endmodule

bind baud_gen baud_gen_checker #(
  .PRE_W(PRE_W),
  .DIV_W(DIV_W),
  .FIN_W(FIN_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .run      (strobes.run),
  .preTc    (strobes.preTc),
  .longPer  (u_ctrl.halfPhase),
  .preCnt   (preCnt),
  .divCnt   (divCnt),
  .finCnt   (finCnt),
  .ovsTick  (ovsTick),
  .bitStrobe(bitStrobe)
);

// File: tb/baud_gen_test.sv
module baud_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] preSel = '0;
  logic [7:0] divisor = '0;
  logic       syncMode = 1'b0;
  logic       ovsTick;
  logic       bitStrobe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  baud_gen uut (
    .clk(clk), .rstN(rstN), .preSel(preSel), .divisor(divisor),
    .syncMode(syncMode), .ovsTick(ovsTick), .bitStrobe(bitStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitOvs(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!ovsTick && gap < 5000);
  endtask

  task automatic waitBit(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!bitStrobe && gap < 20000);
  endtask

  task automatic goIdle();
    @(negedge clk);
    preSel = '0;
    repeat (40) @(negedge clk);
  endtask

  task automatic start(input int code, input int div, input bit mode);
    int g;
    goIdle();
    divisor  = 8'(div);
    syncMode = mode;
    preSel   = 5'(code);
    waitOvs(g);
  endtask

  task automatic testReset();
    int seen = 0;
    repeat (5) begin
      @(negedge clk);
      if (ovsTick || bitStrobe) seen++;
    end
    rstN = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (ovsTick || bitStrobe) seen++;
    end
    check(seen == 0, "R1 quiet in reset/idle", seen, 0);
  endtask

  task automatic testInteger();
    int g;
    start(7, 0, 0);
    waitOvs(g); check(g == 4, "R2 factor 4 gap", g, 4);
    waitOvs(g); check(g == 4, "R2 factor 4 gap repeat", g, 4);
    start(31, 0, 0);
    waitOvs(g); check(g == 16, "R2 factor 16 gap", g, 16);
    start(1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ovsTick == 1'b1, "R2 factor 1 every clock", ovsTick, 1);
    end
  endtask

  task automatic testHalf();
    int g1, g2;
    start(12, 0, 0);
    waitOvs(g1);
    waitOvs(g2);
    check((g1 == 6 && g2 == 7) || (g1 == 7 && g2 == 6), "R3 alternating 6/7 pair", g1 * 10 + g2, 67);
    waitOvs(g1);
    check(g1 != g2 && (g1 == 6 || g1 == 7), "R3 alternation continues", g1, 13 - g2);
    start(2, 0, 0);
    waitOvs(g1);
    waitOvs(g2);
    check(g1 + g2 == 3 && g1 != g2, "R3 factor 1.5 pair", g1 + g2, 3);
  endtask

  task automatic testDivisor();
    int g;
    start(3, 9, 0);
    waitOvs(g); check(g == 20, "R4 N=10 P=2", g, 20);
    start(7, 2, 0);
    waitOvs(g); check(g == 12, "R4 N=3 P=4", g, 12);
    @(negedge clk);
    check(ovsTick == 1'b0, "R10 tick one cycle wide", ovsTick, 0);
  endtask

  task automatic testModes();
    int g, cnt;
    start(3, 1, 0);
    waitBit(g);
    cnt = 0;
    do begin
      @(negedge clk);
      if (ovsTick) cnt++;
    end while (!bitStrobe && cnt < 100);
    check(cnt == 16, "R5 async ticks per bit", cnt, 16);
    check(ovsTick == 1'b1, "R5 bit coincides with tick", ovsTick, 1);
    start(3, 1, 1);
    waitBit(g);
    waitBit(g); check(g == 8, "R6 sync bit gap", g, 8);
    waitBit(g); check(g == 8, "R6 sync bit gap repeat", g, 8);
  endtask

  task automatic testExample();
    int g, a, b;
    start(12, 4, 0);
    waitBit(g);
    waitBit(g); check(g == 520, "R9 async bit gap", g, 520);
    waitOvs(a);
    waitOvs(b); check(a + b == 65, "R9 tick pair sum", a + b, 65);
    start(12, 4, 1);
    waitBit(g);
    waitBit(g); check(g == 65, "R9 sync bit gap", g, 65);
  endtask

  task automatic testReload();
    int g;
    start(15, 0, 0);
    repeat (3) @(negedge clk);
    preSel = 5'd3;
    waitOvs(g); check(g + 3 == 8, "R8 old period completes", g + 3, 8);
    waitOvs(g); check(g == 2, "R8 new factor applies", g, 2);
  endtask

  task automatic testDisable();
    int seen = 0;
    start(3, 9, 0);
    repeat (5) @(negedge clk);
    goIdle();
    repeat (300) begin
      @(negedge clk);
      if (ovsTick || bitStrobe) seen++;
    end
    check(seen == 0, "R7 no pulses after code 0", seen, 0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testInteger();
        testHalf();
        testDivisor();
        testModes();
        testExample();
        testReload();
        testDisable();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule